// File: doc/BRIEF.md
# Decimating Random Word Collector

This block assembles wide random values from a stream of 32-bit samples produced by a hardware entropy source. It does not concatenate neighbouring samples. It retains one sample, then accepts and throws away a fixed run of later samples. It retains the next sample and repeats this until the requested width is filled. The aim is to weaken any correlation between adjacent samples before the value reaches an entropy consumer, such as the seed input of a deterministic generator.

A request is made by pulsing a start input. The width is chosen on the same cycle: 128 bits or 256 bits. While a request is in progress, the block holds its stream ready high, so every source word is handshaken, including the words it discards. When the last retained word lands, the block pulses a one-cycle completion flag. The assembled value then stays on the output until the next accepted request.

Top module: `rnd_decim_collector`

## Requirements
- R1: `src_ready_o` is high from the cycle after an accepted start until the cycle in which `done_o` pulses, and low at every other time, including after reset.
- R2: The first word handshaken after an accepted start is retained. Each retained word is followed by exactly 32 handshaken words that are discarded before the next word is retained, so no two retained words are adjacent in the source stream.
- R3: With `wide_sel_i` = 0 at the accepted start, 4 words are retained and exactly 100 source words are handshaken. With `wide_sel_i` = 1, 8 words are retained and exactly 232 source words are handshaken.
- R4: The k-th retained word (k counting from 0) occupies bits [32k+31:32k] of `result_o`. In a 128-bit request, bits [255:128] read zero.
- R5: `done_o` is high for exactly one cycle, in the cycle after the handshake of the final retained word, and `src_ready_o` is low in that same cycle.
- R6: An accepted start clears `result_o` to zero. After that, `result_o` changes only when a retained word is written, and it holds its value after completion until the next accepted start.
- R7: A start pulse during a collection is ignored, together with the `wide_sel_i` value presented with it. The width is fixed for the whole collection by the value sampled at the accepted start.
- R8: A source word is consumed only in a cycle where both `src_valid_i` and `src_ready_o` are high. Cycles without `src_valid_i` do not advance the retain/discard sequence.
- R9: A synchronous reset (`rst` high at a clock edge) ends any collection, drives `src_ready_o` and `done_o` low, and clears `result_o` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| start_i | input | 1 | Request pulse; accepted only when no collection is active |
| wide_sel_i | input | 1 | Width for the request: 0 = 128 bits, 1 = 256 bits |
| src_data_i | input | 32 | Raw random word from the source |
| src_valid_i | input | 1 | Source word present |
| src_ready_o | output | 1 | Collector accepts source words (collection active) |
| result_o | output | 256 | Assembled value, retained words packed from bit 0 upward |
| done_o | output | 1 | One-cycle pulse when the value is complete |

## Verification
On every cycle, the assertions check the following:
- a retained word is never followed directly by another retained word;
- the discard counter never exceeds its run length;
- `done_o` is a single-cycle pulse that never coincides with a high `src_ready_o`;
- the output register is untouched unless a retained word or a clearing start arrives;
- the sequence state stays frozen while the source is idle.

Some behaviour can only be shown by the directed scenarios, because it depends on the counting pattern fed by the bench:
- which source word lands in which 32-bit slot;
- the exact count of 100 or 232 consumed words;
- that a start and a width change during a collection leave the result intact;
- that a reset in mid-collection restores the idle state.

// File: rtl/rdc_pkg.sv
`timescale 1ns/1ps
package rdc_pkg;
   typedef enum logic {
      SEL_NARROW = 1'b0,
      SEL_WIDE   = 1'b1
   } width_sel_e;

   // source words consumed for a request of n retained words
   function automatic int unsigned words_consumed(input int unsigned n, input int unsigned skip);
      return n + (n - 1) * skip;
   endfunction
endpackage

// File: rtl/rdc_pace.sv
`timescale 1ns/1ps
module rdc_pace #(
   parameter int unsigned SKIP_LEN = 32,
   parameter int unsigned SLOTS    = 8,
   localparam int unsigned IDX_W   = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int unsigned SKIP_W  = $clog2(SKIP_LEN + 1)
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             clear_i,
   input  logic             beat_i,
   input  logic [IDX_W-1:0] last_slot_i,
   output logic             keep_o,
   output logic             last_keep_o,
   output logic [IDX_W-1:0] slot_o
);
   localparam logic [SKIP_W-1:0] SKIP_RELOAD = SKIP_W'(SKIP_LEN);

   logic [SKIP_W-1:0] skip_q;
   logic [IDX_W-1:0]  slot_q;
   logic              skip_done;

   assign skip_done   = (skip_q == '0);
   assign keep_o      = beat_i && skip_done;
   assign last_keep_o = keep_o && (slot_q == last_slot_i);
   assign slot_o      = slot_q;

   always_ff @(posedge clk) begin
      if (rst || clear_i) begin
         skip_q <= '0;
         slot_q <= '0;
      end else if (beat_i) begin
         if (skip_done) begin
            skip_q <= SKIP_RELOAD;
            slot_q <= slot_q + 1'b1;
         end else begin
            skip_q <= skip_q - 1'b1;
         end
      end
   end

   // R2
   skip_range_chk: assert property (@(posedge clk) disable iff (rst)
      skip_q <= SKIP_RELOAD);

   // R2
   no_adjacent_keep_chk: assert property (@(posedge clk) disable iff (rst)
      keep_o |=> !keep_o);
endmodule

// File: rtl/rdc_pack.sv
`timescale 1ns/1ps
module rdc_pack #(
   parameter int unsigned WORD_W = 32,
   parameter int unsigned SLOTS  = 8,
   localparam int unsigned IDX_W = (SLOTS > 1) ? $clog2(SLOTS) : 1,
   localparam int unsigned OUT_W = WORD_W * SLOTS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              clear_i,
   input  logic              wr_en_i,
   input  logic [IDX_W-1:0]  wr_slot_i,
   input  logic [WORD_W-1:0] wr_data_i,
   output logic [OUT_W-1:0]  result_o
);
   for (genvar s = 0; s < SLOTS; s++) begin : g_slot
      logic [WORD_W-1:0] word_q;
      always_ff @(posedge clk) begin
         if (rst || clear_i) begin
            word_q <= '0;
         end else if (wr_en_i && (wr_slot_i == IDX_W'(s))) begin
            word_q <= wr_data_i;
         end
      end
      assign result_o[s*WORD_W +: WORD_W] = word_q;
   end

   // R6
   result_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!wr_en_i && !clear_i) |=> $stable(result_o));
endmodule

// File: rtl/rnd_decim_collector.sv
`timescale 1ns/1ps
module rnd_decim_collector #(
   parameter int unsigned WORD_W       = 32,
   parameter int unsigned SKIP_LEN     = 32,
   parameter int unsigned NARROW_WORDS = 4,
   parameter int unsigned WIDE_WORDS   = 8,
   localparam int unsigned IDX_W = (WIDE_WORDS > 1) ? $clog2(WIDE_WORDS) : 1,
   localparam int unsigned OUT_W = WORD_W * WIDE_WORDS
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              start_i,
   input  logic              wide_sel_i,
   input  logic [WORD_W-1:0] src_data_i,
   input  logic              src_valid_i,
   output logic              src_ready_o,
   output logic [OUT_W-1:0]  result_o,
   output logic              done_o
);
   import rdc_pkg::*;

   localparam logic [IDX_W-1:0] NARROW_LAST = IDX_W'(NARROW_WORDS - 1);
   localparam logic [IDX_W-1:0] WIDE_LAST   = IDX_W'(WIDE_WORDS - 1);

   if (SKIP_LEN < 1) begin : g_bad_skip
      $error("SKIP_LEN must be at least 1");
   end
   if (NARROW_WORDS < 1 || NARROW_WORDS > WIDE_WORDS) begin : g_bad_words
      $error("NARROW_WORDS must lie in 1..WIDE_WORDS");
   end

   logic             active_q;
   logic             done_q;
   logic [IDX_W-1:0] last_slot_q;
   logic             start_ok;
   logic             beat;
   logic             keep;
   logic             last_keep;
   logic [IDX_W-1:0] slot;
   width_sel_e       sel;

   assign sel      = width_sel_e'(wide_sel_i);
   assign start_ok = start_i && !active_q;
   assign beat     = active_q && src_valid_i;

   always_ff @(posedge clk) begin
      if (rst) begin
         active_q    <= 1'b0;
         done_q      <= 1'b0;
         last_slot_q <= '0;
      end else begin
         done_q <= last_keep;
         if (start_ok) begin
            active_q    <= 1'b1;
            last_slot_q <= (sel == SEL_WIDE) ? WIDE_LAST : NARROW_LAST;
         end else if (last_keep) begin
            active_q <= 1'b0;
         end
      end
   end

   rdc_pace #(
      .SKIP_LEN (SKIP_LEN),
      .SLOTS    (WIDE_WORDS)
   ) pace_i (
      .clk         (clk),
      .rst         (rst),
      .clear_i     (start_ok),
      .beat_i      (beat),
      .last_slot_i (last_slot_q),
      .keep_o      (keep),
      .last_keep_o (last_keep),
      .slot_o      (slot)
   );

   rdc_pack #(
      .WORD_W (WORD_W),
      .SLOTS  (WIDE_WORDS)
   ) pack_i (
      .clk       (clk),
      .rst       (rst),
      .clear_i   (start_ok),
      .wr_en_i   (keep),
      .wr_slot_i (slot),
      .wr_data_i (src_data_i),
      .result_o  (result_o)
   );

   assign src_ready_o = active_q;
   assign done_o      = done_q;

   // R1
   ready_after_start_chk: assert property (@(posedge clk) disable iff (rst)
      start_ok |=> src_ready_o);

   // R5
   done_not_ready_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |-> !src_ready_o);

   // R5
   done_single_chk: assert property (@(posedge clk) disable iff (rst)
      done_o |=> !done_o);

   // R7
   width_frozen_chk: assert property (@(posedge clk) disable iff (rst)
      (src_ready_o && start_i) |=> $stable(last_slot_q));

   // R8
   idle_source_chk: assert property (@(posedge clk) disable iff (rst)
      (src_ready_o && !src_valid_i) |=> ($stable(slot) && $stable(result_o)));
endmodule

// File: tb/rnd_decim_collector_tb_top.sv
`timescale 1ns/1ps
module rnd_decim_collector_tb_top;
   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic         start_i = 1'b0;
   logic         wide_sel_i = 1'b0;
   logic [31:0]  src_data_i = '0;
   logic         src_valid_i = 1'b0;
   logic         src_ready_o;
   logic [255:0] result_o;
   logic         done_o;

   int unsigned  n_tests = 0;
   int unsigned  n_fail  = 0;
   logic [31:0]  feed_val = 32'h1000_0000;
   bit           finished = 1'b0;

   always #2 clk = ~clk;

   rnd_decim_collector dut_i (
      .clk         (clk),
      .rst         (rst),
      .start_i     (start_i),
      .wide_sel_i  (wide_sel_i),
      .src_data_i  (src_data_i),
      .src_valid_i (src_valid_i),
      .src_ready_o (src_ready_o),
      .result_o    (result_o),
      .done_o      (done_o)
   );

   task automatic chk(input bit ok, input string req, input string what,
                      input logic [255:0] act, input logic [255:0] exp);
      n_tests++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   // Runs one request; gap_mod > 0 drops valid every gap_mod-th cycle.
   task automatic run_collect(input bit wide, input int gap_mod, input bit poke, input string tag);
      logic [255:0] exp;
      logic [31:0]  base;
      int unsigned  consumed;
      int unsigned  n;
      int           cyc;
      bit           take;
      bit           seen;
      n = wide ? 8 : 4;
      @(negedge clk);
      wide_sel_i = wide; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; wide_sel_i = ~wide;
      chk(src_ready_o == 1'b1, "R1", {tag, " ready after start"}, 256'(src_ready_o), 256'd1);
      chk(result_o == '0, "R6", {tag, " cleared by start"}, result_o, '0);
      base = feed_val; consumed = 0; cyc = 0; seen = 1'b0;
      while (!seen && cyc < 2000) begin
         src_valid_i = (gap_mod == 0) || (cyc % gap_mod != 0);
         src_data_i  = feed_val;
         start_i     = poke && (cyc == 50);
         wide_sel_i  = (cyc == 50) ? ~wide : wide_sel_i;
         take = src_valid_i && src_ready_o;
         @(negedge clk);
         if (take) begin feed_val++; consumed++; end
         seen = done_o;
         cyc++;
      end
      start_i = 1'b0;
      exp = '0;
      for (int k = 0; k < int'(n); k++) exp[32*k +: 32] = base + 32'(33*k);
      chk(seen, "R5", {tag, " done seen"}, 256'(seen), 256'd1);
      chk(consumed == rdc_pkg::words_consumed(n, 32), "R3", {tag, " words consumed"},
          256'(consumed), 256'(rdc_pkg::words_consumed(n, 32)));
      chk(result_o == exp, "R4", {tag, " slot packing (R2 spacing, R7 width)"}, result_o, exp);
      chk(src_ready_o == 1'b0, "R5", {tag, " ready low with done"}, 256'(src_ready_o), '0);
      src_valid_i = 1'b1; src_data_i = 32'hDEAD_BEEF;
      @(negedge clk);
      chk(done_o == 1'b0, "R5", {tag, " done one cycle"}, 256'(done_o), '0);
      for (int k = 0; k < 3; k++) @(negedge clk);
      chk(result_o == exp, "R6", {tag, " result holds"}, result_o, exp);
      chk(src_ready_o == 1'b0, "R8", {tag, " no consumption when idle"}, 256'(src_ready_o), '0);
      src_valid_i = 1'b0;
   endtask

   task automatic t_reset_state;
      chk(src_ready_o == 1'b0, "R9", "reset ready", 256'(src_ready_o), '0);
      chk(done_o == 1'b0, "R9", "reset done", 256'(done_o), '0);
      chk(result_o == '0, "R9", "reset result", result_o, '0);
   endtask

   task automatic t_midrun_reset;
      @(negedge clk);
      wide_sel_i = 1'b1; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0; src_valid_i = 1'b1;
      for (int k = 0; k < 40; k++) begin
         src_data_i = feed_val;
         @(negedge clk);
         feed_val++;
      end
      src_valid_i = 1'b0; rst = 1'b1;
      @(negedge clk);
      rst = 1'b0;
      chk(src_ready_o == 1'b0, "R9", "midrun reset ready", 256'(src_ready_o), '0);
      chk(done_o == 1'b0, "R9", "midrun reset done", 256'(done_o), '0);
      chk(result_o == '0, "R9", "midrun reset result", result_o, '0);
   endtask

   initial begin
      #(4 * 200000);
      if (!finished) begin
         n_fail++; n_tests++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_state();
      rst = 1'b0;
      @(negedge clk);
      run_collect(1'b0, 0, 1'b0, "narrow");
      run_collect(1'b1, 3, 1'b0, "wide gaps");
      run_collect(1'b0, 5, 1'b1, "narrow poke");
      run_collect(1'b1, 0, 1'b1, "wide poke");
      t_midrun_reset();
      run_collect(1'b0, 2, 1'b0, "after reset");
      finished = 1'b1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end
endmodule